// File: doc/BRIEF.md
# I2C Byte-Wide Serial EEPROM Target

This block is an I2C target that acts like a 64-Kbit serial EEPROM built from an 8192 x 8 on-chip RAM. A system clock much faster than SCL oversamples both bus lines. SDA is driven only low, through an open-drain enable. The block finds start and stop conditions and compares the address byte with three strap inputs. A controller loads a two-byte word address, then writes bytes or up to a full 32-byte page, or reads back from the current pointer, from a loaded address, or as a continuous stream.

Written bytes first collect in a page buffer. They reach the RAM only after the stop that closes a write. A busy period of a configurable number of system clocks follows that stop. During it the target ignores the bus completely, so a controller can poll for completion by sending the address byte until the target acknowledges it. A write-protect input blocks every array update.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A falling SDA while SCL is high is a start. It resets the bit count and makes the next byte a device address byte, even if the start arrives in the middle of a byte.
- R2: The address byte is checked bit by bit. Bits 7..4 must be 1010 and bits 3..1 must equal strap_i[2:0]. Bit 0 selects read when 1 and write when 0. On a match the target pulls SDA low for the whole ninth clock.
- R3: A mismatching address byte gets no acknowledge. The target then never drives SDA until the next start.
- R4: After a write address byte, the target takes two word-address bytes, high byte first, and acknowledges each. Only the low 13 bits count, so the top three bits of the high byte are ignored.
- R5: Each written data byte is acknowledged. The bytes fill one 32-byte page. Only address bits 4..0 step, wrapping to the start of the same page, so a later byte overwrites an earlier one at the same offset.
- R6: Buffered data reaches the array only on a stop that follows a whole byte. A busy period of WRITE_CYCLES system clocks then starts, and during it no address byte is acknowledged. Once it ends, the address is acknowledged again.
- R7: If wp_i is high at the closing stop, the array does not change and no busy period begins.
- R8: The pointer always holds the last accessed address plus one: page-wrapped after a write, and across the full array after a read. A current-address read returns the byte at the pointer.
- R9: A read keeps streaming bytes while the controller acknowledges each one. The address wraps from 8191 to 0. After a controller NACK the target releases SDA and waits for a start.
- R10: The target changes its SDA drive only while SCL is low. Read data is sent MSB first.
- R11: A start or stop in the middle of a data byte discards the buffered bytes. Nothing is written and no busy period follows.
- R12: While reset is held and directly after it, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When 1, the target pulls SDA low |
| strap_i | input | 3 | Strap value the address bits 3..1 must match |
| wp_i | input | 1 | High blocks all array writes |
| Verification | | | |

## Verification
The bench sends a 35-byte write that starts four bytes before a page end. It then reads the whole page back. A design that carried into the page bits, or that kept the first copy of an overwritten offset, shows wrong bytes there. A stop three bits into a data byte and a start in the middle of a byte are both followed by an immediate poll and a read-back. A design that committed the partial transfer would return a changed byte, and one that entered the busy period would leave that poll without an acknowledge. A read across address 8191, a read right after a single-byte write, and a protected write each expose a pointer that wraps in the wrong place or a write-protect that is ignored. Mismatching address bytes and polls during the busy period run under a per-clock monitor that flags any SDA drive, and that monitor also flags any drive change while SCL is high.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

    localparam logic [3:0] TYPE_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT,
        ST_BUSY
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] scl_sync_q, sda_sync_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= {scl_sync_q[STAGES-2:0], scl_i};
            sda_sync_q <= {sda_sync_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_sync_q[STAGES-1];
            sda_prev_q <= sda_sync_q[STAGES-1];
        end
    end

    assign scl_o   = scl_sync_q[STAGES-1];
    assign sda_o   = sda_sync_q[STAGES-1];
    assign rise_o  = scl_o & ~scl_prev_q;
    assign fall_o  = ~scl_o & scl_prev_q;
    assign start_o = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o  = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/i2c_page_buffer.sv
module i2c_page_buffer #(
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [PAGE_W-1:0] widx_i,
    input  logic [7:0]        wdata_i,
    input  logic [PAGE_W-1:0] ridx_i,
    output logic [7:0]        rdata_o,
    output logic              rvalid_o,
    output logic              any_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (we_i) slot_q[widx_i] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     valid_q <= '0;
        else if (clr_i) valid_q <= '0;
        else if (we_i)  valid_q[widx_i] <= 1'b1;
    end

    assign rdata_o  = slot_q[ridx_i];
    assign rvalid_o = valid_q[ridx_i];
    assign any_o    = |valid_q;

    // R11: a clear leaves no byte pending for the next commit
    p_clear_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !any_o);

endmodule

// File: rtl/i2c_eeprom_ram.sv
module i2c_eeprom_ram #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cell_q[waddr_i] <= wdata_i;
        rdata_o <= cell_q[raddr_i];
    end

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_eeprom_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int PAGE_W       = 5,
    parameter int WRITE_CYCLES = 50000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);
    localparam int PAGE_BYTES  = 1 << PAGE_W;
    localparam int BUSY_CYCLES = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;
    localparam int CNT_W       = $clog2(BUSY_CYCLES + 1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
    localparam logic [PAGE_W-1:0] PG_ONE   = 1;

    typedef struct packed {
        tgt_state_e        st;
        logic [3:0]        bits;
        logic              ackph;
        logic              mack;
        logic              oe;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  busy;
    } ctrl_t;

    ctrl_t q, d;

    logic scl_s, sda_s, ev_start, ev_stop, ev_rise, ev_fall;
    logic buf_we, buf_clr, buf_rvalid, buf_any, ram_we;
    logic [7:0] buf_rdata, ram_rdata;

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .start_o(ev_start), .stop_o(ev_stop),
        .rise_o(ev_rise), .fall_o(ev_fall)
    );

    i2c_page_buffer #(.PAGE_W(PAGE_W)) u_page (
        .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .we_i(buf_we),
        .widx_i(q.ptr[PAGE_W-1:0]), .wdata_i(q.sh),
        .ridx_i(q.busy[PAGE_W-1:0]), .rdata_o(buf_rdata),
        .rvalid_o(buf_rvalid), .any_o(buf_any)
    );

    i2c_eeprom_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we_i(ram_we),
        .waddr_i({q.ptr[ADDR_W-1:PAGE_W], q.busy[PAGE_W-1:0]}),
        .wdata_i(buf_rdata), .raddr_i(q.ptr), .rdata_o(ram_rdata)
    );

    always_comb begin
        d       = q;
        buf_we  = 1'b0;
        buf_clr = 1'b0;
        ram_we  = 1'b0;
        if (q.st == ST_BUSY) begin
            // bus ignored; first PAGE_BYTES cycles drain the page buffer
            d.busy = q.busy + CNT_W'(1);
            if (q.busy < CNT_W'(PAGE_BYTES)) ram_we = buf_rvalid;
            if (q.busy == CNT_W'(BUSY_CYCLES - 1)) begin
                d.st    = ST_IDLE;
                buf_clr = 1'b1;
            end
        end else if (ev_start) begin
            d.st    = ST_DEV;
            d.bits  = 4'd0;
            d.ackph = 1'b0;
            d.oe    = 1'b0;
            buf_clr = 1'b1;
        end else if (ev_stop) begin
            d.bits  = 4'd0;
            d.ackph = 1'b0;
            d.oe    = 1'b0;
            d.busy  = '0;
            if (q.st == ST_WDAT && q.bits <= 4'd1 && !q.ackph && buf_any && !wp_i) begin
                d.st = ST_BUSY;
            end else begin
                d.st    = ST_IDLE;
                buf_clr = 1'b1;
            end
        end else if (q.st != ST_IDLE) begin
            if (ev_rise) begin
                if (q.ackph) begin
                    d.mack = ~sda_s;
                end else if (q.bits != 4'd8) begin
                    d.bits = q.bits + 4'd1;
                    if (q.st != ST_RDAT) d.sh = {q.sh[6:0], sda_s};
                end
            end else if (ev_fall) begin
                if (q.ackph) begin
                    d.ackph = 1'b0;
                    d.bits  = 4'd0;
                    d.oe    = 1'b0;
                    if (q.st == ST_RDAT) begin
                        if (q.mack) begin
                            d.sh  = ram_rdata;
                            d.oe  = ~ram_rdata[7];
                            d.ptr = q.ptr + ADDR_ONE;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end else if (q.st == ST_RDAT) begin
                    if (q.bits == 4'd8) begin
                        d.oe    = 1'b0;
                        d.ackph = 1'b1;
                        d.mack  = 1'b0;
                    end else if (q.bits != 4'd0) begin
                        d.sh = {q.sh[6:0], 1'b0};
                        d.oe = ~q.sh[6];
                    end
                end else if (q.bits == 4'd8) begin
                    d.ackph = 1'b1;
                    d.oe    = 1'b1;
                    case (q.st)
                        ST_DEV: begin
                            if (q.sh[7:4] == TYPE_CODE && q.sh[3:1] == strap_i) begin
                                d.st   = q.sh[0] ? ST_RDAT : ST_AHI;
                                d.mack = 1'b1;
                            end else begin
                                d.st    = ST_IDLE;
                                d.ackph = 1'b0;
                                d.oe    = 1'b0;
                            end
                        end
                        ST_AHI: begin
                            d.ptr[ADDR_W-1:8] = q.sh[ADDR_W-9:0];
                            d.st = ST_ALO;
                        end
                        ST_ALO: begin
                            d.ptr[7:0] = q.sh;
                            d.st = ST_WDAT;
                        end
                        ST_WDAT: begin
                            buf_we = 1'b1;
                            d.ptr[PAGE_W-1:0] = q.ptr[PAGE_W-1:0] + PG_ONE;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.bits  <= 4'd0;
            q.ackph <= 1'b0;
            q.mack  <= 1'b0;
            q.oe    <= 1'b0;
            q.sh    <= 8'd0;
            q.ptr   <= '0;
            q.busy  <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

    // R10: drive changes only in the SCL low phase
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> !scl_s);
    // R6: silent for the whole write cycle
    p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BUSY) |-> !q.oe);
    // R7: write cycle entered only from an unprotected stop
    p_busy_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BUSY && $past(q.st) != ST_BUSY) |-> ($past(ev_stop) && !$past(wp_i)));
    // R1: a start restarts byte framing at the address byte
    p_start_frames_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && q.st != ST_BUSY) |=> (q.st == ST_DEV && q.bits == 4'd0 && !q.ackph));
    // R5: data bytes never move the page bits
    p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WDAT && $past(q.st) == ST_WDAT) |->
        (q.ptr[ADDR_W-1:PAGE_W] == $past(q.ptr[ADDR_W-1:PAGE_W])));
    // R3: no drive while idle
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe);

endmodule

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int H          = 8;
    localparam int WCYC       = 400;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    i2c_eeprom_target #(.WRITE_CYCLES(WCYC)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(STRAP), .wp_i(wp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, ptr_m = 0;
    bit quiet = 1'b0, done = 1'b0;
    logic [7:0] mem_m [int];
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the expected bus behaviour
    always @(negedge clk) begin
        if (rst_n) begin
            if (quiet) begin
                checks++;
                if (sda_oe) begin
                    errors++;
                    $display("FAIL R3 actual=1 expected=0 (SDA driven in silent window)");
                end
            end
            if (scl_m && prev_scl) begin
                checks++;
                if (sda_oe !== prev_oe) begin
                    errors++;
                    $display("FAIL R10 actual=%0b expected=%0b (drive changed while SCL high)", sda_oe, prev_oe);
                end
            end
        end
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic w(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(bit rd);
        return {4'b1010, STRAP, rd};
    endfunction

    task automatic start_c();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(H); sda_m = 1'b0; w(H); scl_m = 1'b0;
    endtask

    task automatic stop_c();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(H); sda_m = 1'b1; w(H);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            w(Q); sda_m = b[i]; w(Q); scl_m = 1'b1; w(H); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(logic [7:0] b, output bit ack);
        send_bits(b, 8);
        w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
        ack = !sda_line;
        w(Q); scl_m = 1'b0;
    endtask

    task automatic recv_byte(bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(H); scl_m = 1'b1; w(Q); b[i] = sda_line; w(Q); scl_m = 1'b0;
        end
        w(Q); sda_m = !give_ack; w(Q); scl_m = 1'b1; w(H); scl_m = 1'b0; w(Q); sda_m = 1'b1;
    endtask

    task automatic set_ptr(int a, logic [2:0] junk);
        bit ack;
        logic [7:0] hi;
        hi = {junk, 5'(a >> 8)};
        start_c();
        send_byte(dev(1'b0), ack); chk(ack, "R2 write address ack", ack, 1);
        send_byte(hi, ack);        chk(ack, "R4 high address ack", ack, 1);
        send_byte(8'(a), ack);     chk(ack, "R4 low address ack", ack, 1);
        ptr_m = a & 8191;
    endtask

    task automatic poll(bit expect_busy);
        bit ack;
        int polls = 0;
        quiet = expect_busy;
        start_c(); send_byte(dev(1'b0), ack); quiet = 1'b0; stop_c();
        if (expect_busy) chk(!ack, "R6 no ack during write cycle", ack, 0);
        else             chk(ack, "R7/R11 no write cycle started", ack, 1);
        while (!ack && polls < 20) begin
            start_c(); send_byte(dev(1'b0), ack); stop_c();
            polls++;
        end
        chk(ack, "R6 ack after write cycle", ack, 1);
    endtask

    task automatic write_bytes(int a, int n, logic [7:0] base, logic [2:0] junk, bit expect_busy);
        bit ack;
        logic [7:0] dv;
        set_ptr(a, junk);
        for (int i = 0; i < n; i++) begin
            dv = base + 8'(i);
            send_byte(dv, ack); chk(ack, "R5 data ack", ack, 1);
            if (!wp) mem_m[(a & ~31) | ((a + i) & 31)] = dv;
        end
        ptr_m = (a & ~31) | ((a + n) & 31);
        stop_c();
        poll(expect_busy);
    endtask

    task automatic read_cur(int n, string req);
        bit ack;
        logic [7:0] b;
        start_c();
        send_byte(dev(1'b1), ack); chk(ack, "R2 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            if (mem_m.exists(ptr_m)) chk(b == mem_m[ptr_m], req, b, mem_m[ptr_m]);
            ptr_m = (ptr_m + 1) % 8192;
        end
        stop_c();
    endtask

    task automatic read_at(int a, int n, string req);
        set_ptr(a, 3'b000);
        read_cur(n, req);
    endtask

    initial begin
        bit ack;
        w(5);
        chk(sda_oe == 1'b0, "R12 released in reset", sda_oe, 0);
        rst_n = 1'b1;
        w(10);
        chk(sda_oe == 1'b0, "R12 released after reset", sda_oe, 0);

        // R3: strap mismatch and following byte both ignored
        quiet = 1'b1;
        start_c();
        send_byte({4'b1010, 3'b100, 1'b0}, ack); chk(!ack, "R3 strap mismatch", ack, 0);
        send_byte(8'h00, ack);                   chk(!ack, "R3 ignored until start", ack, 0);
        stop_c();
        // R2: wrong type code
        start_c();
        send_byte({4'b1011, STRAP, 1'b0}, ack);  chk(!ack, "R2 type code", ack, 0);
        stop_c();
        quiet = 1'b0;

        // R6/R8: byte write, then random read
        write_bytes(16'h0005, 1, 8'hA5, 3'b000, 1'b1);
        read_at(16'h0005, 1, "R8 random read");

        // R8: pointer after single-byte write
        write_bytes(16'h0041, 1, 8'h66, 3'b000, 1'b1);
        write_bytes(16'h0040, 1, 8'h55, 3'b000, 1'b1);
        read_cur(1, "R8 current read after write");

        // R4/R5: 35 bytes near page end with junk upper bits
        write_bytes(16'h011C, 35, 8'h40, 3'b111, 1'b1);
        read_at(16'h0100, 32, "R5 page wrap");

        // R7: protected write
        wp = 1'b1;
        write_bytes(16'h0100, 1, 8'hEE, 3'b000, 1'b0);
        wp = 1'b0;
        read_at(16'h0100, 1, "R7 protected byte unchanged");

        // R11: stop mid-byte discards
        write_bytes(16'h0200, 1, 8'h77, 3'b000, 1'b1);
        set_ptr(16'h0200, 3'b000);
        send_byte(8'h99, ack); chk(ack, "R5 data ack", ack, 1);
        send_bits(8'hA0, 3);
        stop_c();
        poll(1'b0);
        read_at(16'h0200, 1, "R11 stop abort");
        // R1: start mid-byte discards and restarts framing
        set_ptr(16'h0200, 3'b000);
        send_byte(8'h98, ack); chk(ack, "R5 data ack", ack, 1);
        send_bits(8'h50, 3);
        read_at(16'h0200, 1, "R1 start abort");

        // R9: sequential read wraps from the last byte to 0
        write_bytes(16'h1FFF, 1, 8'h3C, 3'b000, 1'b1);
        write_bytes(16'h0000, 1, 8'hC3, 3'b000, 1'b1);
        read_at(16'h1FFF, 2, "R9 array wrap");
        w(4);
        chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule